// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block holds a calendar clock in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month and two-digit year. Software reaches it through a byte-wide bus modelled on an asynchronous static RAM. The bus has an active-low chip select, an active-low output enable and an active-low write enable, all sampled on a system clock. The read path is split into a data output and a drive-enable flag: drive-enable low stands for the pad being high-impedance. Two single-cycle enable pulses act as the time bases. One arrives once a second and advances the clock. The other arrives 512 times a second and only drives a test toggle. No clock is derived from either pulse.

Software never reads the counters directly. It sees a copy of them that follows the counters on every cycle while both freeze bits in the control byte are clear. When either bit is set, the copy stops changing, so a multi-byte read returns a single instant. The counters go on counting behind the frozen copy. While the write-freeze bit is set, software loads new values into the copy. Clearing that bit moves the loaded values into the counters. A stop bit in the seconds byte halts timekeeping. A test bit in the day byte makes the seconds LSB toggle at 512 Hz, so the time base can be measured at the pins.

Top module: `rtc_bcd_bank`

## Requirements
- R1: The data output drives (data_oe=1) only when cs_n=0, we_n=1 and oe_n=0. Otherwise data_oe=0 and data_out=0. A write takes place on every clock where cs_n=0 and we_n=0, whatever the value of oe_n.
- R2: After reset the registers read as follows: control 00, seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00. The stop bit and the test bit are both 0.
- R3: While control bit 6 (read-freeze) or bit 7 (write-freeze) is 1, reads return the value the copy held when the freeze took effect, and 1 Hz ticks keep advancing the hidden counters. Once both bits are clear, reads follow the counters again, one clock behind them.
- R4: While control bit 7 is 1, writes to addresses 1 to 7 load the matching time field of the copy. While it is 0, the time-field bits of those writes are discarded.
- R5: A write to address 0 with bit 7 = 0, made while bit 7 was 1, loads all seven fields of the copy into the counters at that clock edge. Counting then continues from the loaded values.
- R6: Bit 7 of the seconds byte is the stop bit. Any write to address 1 sets or clears it at once, whatever the state of the freeze bits. While it is 1, 1 Hz ticks leave the time unchanged. It reads back as bit 7 of address 1.
- R7: Seconds and minutes count 00 to 59 in BCD and wrap to 00. Hours count 00 to 23 and wrap to 00, which carries one day.
- R8: On a day carry, day-of-week (bits 2:0 of address 4) goes from 7 back to 1. A date at the last day of its month becomes 01 and the month advances. February ends at 29 when the year is divisible by 4, otherwise at 28. April, June, September and November end at 30, and the other months at 31. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R9: Bit 6 of the day byte is the test bit. While it is 1 and the stop bit is 0, each 512 Hz pulse inverts bit 0 of the value read at address 1, including during one continuous read. While the stop bit is 1 the inversion state holds. Clearing the test bit removes the inversion.
- R10: Address map: 0 control, 1 seconds (bits 6:0), 2 minutes (bits 6:0), 3 hours (bits 5:0), 4 day (bits 2:0), 5 date (bits 5:0), 6 month (bits 4:0), 7 year. Field bits not listed read 0. Control bits 5:0, and every address from 8 upward, are plain read/write bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tick_512hz | input | 1 | One-cycle pulse at 512 Hz for the test toggle |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data, zero when not driving |
| data_oe | output | 1 | Read data drive enable (low means high-impedance) |

## Verification
The hardest cases to reach are the calendar carries: the end of every month, in both leap and ordinary years, and the year 99 to 00 wrap. Waiting for them with one-second pulses would take far too long. The bench instead uses the write-freeze path to load 23:59:59 on the last date of each month for four consecutive years and for December of year 99. It then applies a single pulse and compares all seven bytes with a calendar computed in the bench. The test toggle is observed during a single held read, with 512 Hz pulses applied in the middle of it, before and after the clock is stopped.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int unsigned MAP_REGS = 8;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SEC  = 3'd1;
  localparam logic [2:0] RA_MIN  = 3'd2;
  localparam logic [2:0] RA_HR   = 3'd3;
  localparam logic [2:0] RA_DAY  = 3'd4;
  localparam logic [2:0] RA_DATE = 3'd5;
  localparam logic [2:0] RA_MON  = 3'd6;
  localparam logic [2:0] RA_YR   = 3'd7;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hr: 6'h00,
                                     dow: 3'd1, date: 6'h01, mon: 5'h01,
                                     yr: 8'h00};

  // Two-digit BCD increment, 99 wraps to 00.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v == 8'h99)          r = 8'h00;
    else if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                     r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by four, decided on the BCD digits directly.
  function automatic logic bcd_leap(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] r;
    case (m)
      5'h02:                      r = bcd_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
`timescale 1ns/1ps
module rtc_bus_decode (
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_en,
  output logic rd_en
);
  // Write enable dominates output enable.
  assign wr_en = !cs_n && !we_n;
  assign rd_en = !cs_n &&  we_n && !oe_n;
endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (load) begin
      cur_d = load_val;
    end else if (adv) begin
      if (cur_q.sec != 7'h59) begin
        cur_d.sec = 7'(bcd_inc({1'b0, cur_q.sec}));
      end else begin
        cur_d.sec = '0;
        if (cur_q.min != 7'h59) begin
          cur_d.min = 7'(bcd_inc({1'b0, cur_q.min}));
        end else begin
          cur_d.min = '0;
          if (cur_q.hr != 6'h23) begin
            cur_d.hr = 6'(bcd_inc({2'b0, cur_q.hr}));
          end else begin
            cur_d.hr  = '0;
            cur_d.dow = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
            if (cur_q.date != last_date(cur_q.mon, cur_q.yr)) begin
              cur_d.date = 6'(bcd_inc({2'b0, cur_q.date}));
            end else begin
              cur_d.date = 6'h01;
              if (cur_q.mon != 5'h12) begin
                cur_d.mon = 5'(bcd_inc({3'b0, cur_q.mon}));
              end else begin
                cur_d.mon = 5'h01;
                cur_d.yr  = bcd_inc(cur_q.yr);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= TIME_RST;
    else        cur_q <= cur_d;
  end

  assign now = cur_q;
endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              tick_fast,
  input  rtc_time_t         live,
  output rtc_time_t         user,
  output logic [7:0]        rdata,
  output logic [1:0]        frz,
  output logic              osc_stop,
  output logic              xfer
);
  localparam int unsigned NSCR   = (1 << ADDR_W) - MAP_REGS;
  localparam int unsigned SIDX_W = $clog2(NSCR);

  logic              in_map;
  logic [2:0]        ra;
  logic [SIDX_W-1:0] sidx;
  logic              wr_map, wr_scr, wr_ctrl;
  logic [7:0]        ctrl_q, ctrl_d;
  rtc_time_t         user_q, user_d;
  logic              osc_q, osc_d, ft_q, ft_d, ph_q, ph_d;
  logic [7:0]        scr_q [NSCR];

  assign in_map  = addr < ADDR_W'(MAP_REGS);
  assign ra      = addr[2:0];
  assign sidx    = SIDX_W'(addr - ADDR_W'(MAP_REGS));
  assign wr_map  = wr_en && in_map;
  assign wr_scr  = wr_en && !in_map;
  assign wr_ctrl = wr_map && (ra == RA_CTRL);
  // Write-freeze falling: copy goes to the live counters this edge.
  assign xfer    = wr_ctrl && ctrl_q[7] && !wdata[7];

  always_comb begin
    ctrl_d = ctrl_q;
    osc_d  = osc_q;
    ft_d   = ft_q;
    user_d = user_q;
    if (wr_ctrl) ctrl_d = wdata;
    if (wr_map && ra == RA_SEC) osc_d = wdata[7];
    if (wr_map && ra == RA_DAY) ft_d  = wdata[6];
    if (ctrl_q[7]) begin
      if (wr_map) begin
        case (ra)
          RA_SEC:  user_d.sec  = wdata[6:0];
          RA_MIN:  user_d.min  = wdata[6:0];
          RA_HR:   user_d.hr   = wdata[5:0];
          RA_DAY:  user_d.dow  = wdata[2:0];
          RA_DATE: user_d.date = wdata[5:0];
          RA_MON:  user_d.mon  = wdata[4:0];
          RA_YR:   user_d.yr   = wdata;
          default: ;
        endcase
      end
    end else if (!ctrl_q[6]) begin
      user_d = live;
    end
    if (!ft_q)                  ph_d = 1'b0;
    else if (tick_fast && !osc_q) ph_d = !ph_q;
    else                        ph_d = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      user_q <= TIME_RST;
      osc_q  <= 1'b0;
      ft_q   <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      user_q <= user_d;
      osc_q  <= osc_d;
      ft_q   <= ft_d;
      ph_q   <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSCR; i++) scr_q[i] <= '0;
    end else if (wr_scr) begin
      scr_q[sidx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (!in_map) begin
      rdata = scr_q[sidx];
    end else begin
      case (ra)
        RA_CTRL: rdata = ctrl_q;
        RA_SEC:  rdata = {osc_q, user_q.sec[6:1], user_q.sec[0] ^ ph_q};
        RA_MIN:  rdata = {1'b0, user_q.min};
        RA_HR:   rdata = {2'b0, user_q.hr};
        RA_DAY:  rdata = {1'b0, ft_q, 3'b0, user_q.dow};
        RA_DATE: rdata = {2'b0, user_q.date};
        RA_MON:  rdata = {3'b0, user_q.mon};
        default: rdata = user_q.yr;
      endcase
    end
  end

  assign user     = user_q;
  assign frz      = ctrl_q[7:6];
  assign osc_stop = osc_q;
endmodule

// File: rtl/rtc_bcd_bank.sv
`timescale 1ns/1ps
module rtc_bcd_bank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              tick_512hz,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       wr_en, rd_en, adv, xfer, osc_stop;
  logic [1:0] frz_bits;
  logic [7:0] rdata;
  rtc_time_t  live_now, user_copy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rtc_bus_decode u_dec (
    .cs_n (cs_n), .oe_n (oe_n), .we_n (we_n),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  assign adv = tick_1hz && !osc_stop;

  rtc_time_chain u_chain (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (adv),
    .load    (xfer),
    .load_val(user_copy),
    .now     (live_now)
  );

  rtc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (data_in),
    .tick_fast(tick_512hz),
    .live     (live_now),
    .user     (user_copy),
    .rdata    (rdata),
    .frz      (frz_bits),
    .osc_stop (osc_stop),
    .xfer     (xfer)
  );

  assign data_oe  = rd_en;
  assign data_out = rd_en ? rdata : 8'h00;
endmodule

// File: rtl/rtc_bcd_bank_chk.sv
`timescale 1ns/1ps
module rtc_bcd_bank_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       data_oe,
  input logic [1:0] frz,
  input rtc_time_t  user,
  input rtc_time_t  live,
  input logic       osc_stop,
  input logic       xfer,
  input logic       adv
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !data_oe);  // R1
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !data_oe);  // R1
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n) |-> data_oe);  // R1
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz == 2'b01) |=> $stable(user));  // R3
  AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (live == $past(user)));  // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !xfer) |=> $stable(live));  // R6
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !xfer && live.sec == 7'h59) |=> (live.sec == 7'h00));  // R7
  AST_HR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !xfer && live.sec == 7'h59 && live.min == 7'h59 && live.hr == 6'h23)
      |=> (live.hr == 6'h00));  // R7
endmodule

bind rtc_bcd_bank rtc_bcd_bank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs_n    (cs_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .data_oe (data_oe),
  .frz     (frz_bits),
  .user    (user_copy),
  .live    (live_now),
  .osc_stop(osc_stop),
  .xfer    (xfer),
  .adv     (adv)
);

// File: tb/rtc_bcd_bank_tb.sv
`timescale 1ns/1ps
module rtc_bcd_bank_tb;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n, tick_1hz, tick_512hz, cs_n, oe_n, we_n, data_oe;
  logic [ADDR_W-1:0] addr;
  logic [7:0] data_in, data_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  bit m_osc, m_ft;

  always #4 clk = ~clk;

  rtc_bcd_bank #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_512hz(tick_512hz),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      1: return {m_osc, 7'(bcd(m_sec))};
      2: return bcd(m_min);
      3: return bcd(m_hr);
      4: return {1'b0, m_ft, 6'(m_dow)};
      5: return bcd(m_date);
      6: return bcd(m_mon);
      default: return bcd(m_yr);
    endcase
  endfunction

  task automatic model_tick();
    if (m_osc) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    m_date++;
    if (m_date <= mdays(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr = (m_yr + 1) % 100;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; addr = ADDR_W'(a); data_in = d;
    @(negedge clk);
    cs_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 0; we_n = 1; oe_n = 0; addr = ADDR_W'(a);
    #1 v = data_out;
    cs_n = 1; oe_n = 1;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    model_tick();
  endtask

  task automatic check_time(input string req);
    logic [7:0] v;
    for (int a = 1; a < 8; a++) begin
      rd(a, v);
      chk(req, v, exp_reg(a));
    end
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dw,
                          input int dt, input int mo, input int y);
    wr(0, 8'h80);
    wr(1, bcd(s)); wr(2, bcd(mi)); wr(3, bcd(h)); wr(4, 8'(dw));
    wr(5, bcd(dt)); wr(6, bcd(mo)); wr(7, bcd(y));
    wr(0, 8'h00);
    m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
    m_osc = 0; m_ft = 0;
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, frozen;
    rst_n = 0; tick_1hz = 0; tick_512hz = 0; cs_n = 1; oe_n = 1; we_n = 1;
    addr = '0; data_in = '0;
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_osc = 0; m_ft = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 reset values, R1 idle bus
    chk("R1 idle", {7'b0, data_oe}, 8'h00);
    rd(0, v); chk("R2 ctrl", v, 8'h00);
    check_time("R2");

    // R1 exhaustive strobe decode
    for (int c = 0; c < 8; c++) begin
      logic exp_oe;
      @(negedge clk);
      cs_n = c[2]; oe_n = c[1]; we_n = c[0]; addr = 4'd8; data_in = 8'hA5;
      exp_oe = !c[2] && c[0] && !c[1];
      #1 chk("R1 oe", {7'b0, data_oe}, {7'b0, exp_oe});
      if (!exp_oe) chk("R1 quiet", data_out, 8'h00);
      @(negedge clk); cs_n = 1; oe_n = 1; we_n = 1;
    end
    // R1 write ignores oe_n
    @(negedge clk); cs_n = 0; we_n = 0; oe_n = 0; addr = 4'd8; data_in = 8'h3C;
    @(negedge clk); cs_n = 1; we_n = 1; oe_n = 1;
    rd(8, v); chk("R1 wr oe0", v, 8'h3C);
    @(negedge clk); cs_n = 0; we_n = 0; oe_n = 1; addr = 4'd8; data_in = 8'hC3;
    @(negedge clk); cs_n = 1; we_n = 1;
    rd(8, v); chk("R1 wr oe1", v, 8'hC3);

    // R10 storage bytes and control low bits
    for (int a = 8; a < 16; a++) wr(a, 8'((a * 37 + 5) & 255));
    for (int a = 8; a < 16; a++) begin
      rd(a, v); chk("R10 scratch", v, 8'((a * 37 + 5) & 255));
    end
    wr(0, 8'h2D); rd(0, v); chk("R10 ctrl", v, 8'h2D);
    wr(0, 8'h00);

    // R7 second/minute/hour wrap sweep
    set_time(50, 58, 23, 3, 15, 6, 21);
    check_time("R5 load");
    for (int k = 0; k < 130; k++) begin
      tick();
      rd(1, v); chk("R7 sec", v, exp_reg(1));
      rd(2, v); chk("R7 min", v, exp_reg(2));
      rd(3, v); chk("R7 hr",  v, exp_reg(3));
    end
    check_time("R7 all");

    // R8 every month end over four years, plus year 99 and date carry
    for (int y = 0; y < 4; y++)
      for (int m = 1; m <= 12; m++) begin
        set_time(59, 59, 23, 7, mdays(m, y), m, y);
        tick();
        check_time("R8 month end");
      end
    set_time(59, 59, 23, 6, 31, 12, 99); tick(); check_time("R8 year wrap");
    set_time(59, 59, 23, 3, 9, 9, 9);    tick(); check_time("R8 date carry");
    set_time(59, 59, 23, 2, 28, 2, 1);   tick(); check_time("R8 feb28");

    // R3 read freeze, background counting
    set_time(10, 20, 5, 2, 3, 4, 5);
    wr(0, 8'h40);
    frozen = bcd(m_sec);
    repeat (3) tick();
    rd(1, v); chk("R3 frozen", v, frozen);
    wr(0, 8'h00);
    check_time("R3 release");

    // R5 write freeze while ticking, load lands in counters
    wr(0, 8'h80);
    repeat (4) tick();
    rd(1, v); chk("R3 wfreeze", v, exp_reg(1) - 8'h04);
    wr(1, bcd(45)); wr(2, bcd(12)); wr(3, bcd(8));
    wr(0, 8'h00);
    m_sec = 45; m_min = 12; m_hr = 8;
    check_time("R5 xfer");
    tick(); check_time("R5 resume");

    // R4 writes with write bit clear discard time fields
    wr(2, 8'h33); wr(3, 8'h11); wr(5, 8'h22);
    check_time("R4 ignored");

    // R6 stop bit
    wr(1, 8'h80 | bcd(m_sec)); m_osc = 1;
    repeat (5) tick();
    check_time("R6 stopped");
    wr(1, 8'h00); m_osc = 0;
    check_time("R6 cleared");
    tick(); check_time("R6 running");

    // R9 test toggle during one held read
    wr(4, 8'h40 | 8'(m_dow)); m_ft = 1;
    rd(4, v); chk("R9 day bit", v, exp_reg(4));
    @(negedge clk); cs_n = 0; we_n = 1; oe_n = 0; addr = 4'd1;
    for (int k = 0; k < 5; k++) begin
      tick_512hz = 1;
      @(negedge clk); tick_512hz = 0;
      #1 chk("R9 toggle", data_out, exp_reg(1) ^ 8'((k + 1) % 2));
      @(negedge clk);
    end
    cs_n = 1; oe_n = 1;
    wr(1, 8'h80); m_osc = 1;
    @(negedge clk); cs_n = 0; we_n = 1; oe_n = 0; addr = 4'd1;
    for (int k = 0; k < 2; k++) begin
      tick_512hz = 1;
      @(negedge clk); tick_512hz = 0;
      #1 chk("R9 stop hold", data_out, exp_reg(1) ^ 8'h01);
      @(negedge clk);
    end
    cs_n = 1; oe_n = 1;
    wr(4, 8'(m_dow)); m_ft = 0;
    rd(1, v); chk("R9 cleared", v, exp_reg(1));
    wr(1, 8'h00); m_osc = 0;
    tick(); check_time("R9 after");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule